// File: doc/BRIEF.md
# Block Memory Mapper with Access Protection

The mapper sits on a 16-bit address bus and divides the 64 KB space into 64 blocks of 1024 bytes. Each block has its own entry in a map table. The entry decides whether an access is served by the memory in the target system or by memory lent from the development host. It can also mark the block write-protected or absent. For blocks served by the host, the entry holds a replacement block number, so the block can sit at a different place in host memory. Address bits 15:10 select the entry, and bits 9:0 pass through unchanged.

The select and address outputs follow the bus inputs combinationally. A write strobe goes to the selected memory only when the write is legal. An illegal access raises a break request. The request is latched in the next clock cycle together with the faulting address and the access direction, and it stays up until the clear input is pulsed. The table is loaded through a simple write port, which only takes effect while emulation is halted.

Top module: `mem_mapper`

## Requirements
- R1: The map index is bus address bits 15:10. Bits 9:0 of the output address always equal bits 9:0 of the bus address.
- R2: A valid access to a block whose entry routes to the target asserts `tgt_sel_o` only, and the output address equals the bus address.
- R3: A valid access to a block whose entry routes to the host asserts `host_sel_o` only, and output bits 15:10 equal the entry's translation field.
- R4: A write to a write-protected block gives no `wr_en_o` and raises a break. A read of that block is selected normally and raises no break.
- R5: Any access to a block marked absent asserts neither select nor `wr_en_o` and raises a break. This holds whatever the block's other fields say.
- R6: A violation sets `brk_o` at the next rising edge and stores the address and write flag. While the break is pending and `brk_clr_i` is low, that stored record does not change. `brk_clr_i` clears the break. If a clear and a violation arrive in the same cycle, the new violation is captured.
- R7: A table write with `emu_run_i` high is ignored.
- R8: After reset, every entry routes to the target, has no protection and no absent flag, and has a translation field equal to its own index. `brk_o` is low.
- R9: A table write with `emu_run_i` low takes effect at the next rising edge and is used by the following accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| emu_run_i | input | 1 | Emulation running; blocks table writes |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | 6 | Entry to write |
| cfg_host_i | input | 1 | 1 = host memory, 0 = target memory |
| cfg_wp_i | input | 1 | Write-protect flag |
| cfg_nx_i | input | 1 | Absent-block flag |
| cfg_xlat_i | input | 6 | Host block number for translation |
| bus_valid_i | input | 1 | Bus access in progress |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 16 | Bus address |
| host_sel_o | output | 1 | Host memory selected |
| tgt_sel_o | output | 1 | Target memory selected |
| wr_en_o | output | 1 | Write strobe that is allowed through |
| phys_addr_o | output | 16 | Translated address |
| brk_clr_i | input | 1 | Clears the latched break |
| brk_o | output | 1 | Break request pending |
| brk_addr_o | output | 16 | Faulting address |
| brk_wr_o | output | 1 | Faulting access was a write |

## Verification
The bench first runs directed accesses: target blocks, host blocks with a translated block number, reads and writes to protected blocks, and an absent block that also carries the host and protect flags. These tell routing apart from translation and show that the absent flag overrides the other fields. A table write made during emulation, followed by an access to the same entry, separates an ignored write from an accepted one. Violations are then sent back to back, with and without a clear in the same cycle, to show which record is kept. A long random phase mixes table writes, the run flag, clears and bus traffic, and every output is compared each cycle against a behavioural model.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef struct packed {
    logic host;
    logic wp;
    logic nx;
  } map_attr_t;
endpackage

// File: rtl/map_table.sv
module map_table import mapper_pkg::*; #(
  parameter int IDX_W   = 6,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  map_attr_t        wr_attr_i,
  input  logic [IDX_W-1:0] wr_xlat_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output map_attr_t        attr_o,
  output logic [IDX_W-1:0] xlat_o
);
  map_attr_t [ENTRIES-1:0]             attr_q;
  logic      [ENTRIES-1:0][IDX_W-1:0]  xlat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        attr_q[i] <= '0;
        xlat_q[i] <= IDX_W'(i);
      end
    end else if (we_i && !lock_i) begin
      attr_q[wr_idx_i] <= wr_attr_i;
      xlat_q[wr_idx_i] <= wr_xlat_i;
    end
  end

  assign attr_o = attr_q[rd_idx_i];
  assign xlat_o = xlat_q[rd_idx_i];

  assert_locked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_i) |=> ($stable(attr_q) && $stable(xlat_q)));
  assert_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lock_i) |=> (attr_q[$past(wr_idx_i)] == $past(wr_attr_i)));
endmodule

// File: rtl/map_decode.sv
module map_decode import mapper_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 10,
  localparam int IDX_W = ADDR_W - OFS_W
) (
  input  logic              valid_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  map_attr_t         attr_i,
  input  logic [IDX_W-1:0]  xlat_i,
  output logic              host_sel_o,
  output logic              tgt_sel_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] phys_o,
  output logic              viol_o
);
  logic present;
  assign present    = valid_i && !attr_i.nx;
  assign host_sel_o = present && attr_i.host;
  assign tgt_sel_o  = present && !attr_i.host;
  assign wr_en_o    = present && wr_i && !attr_i.wp;
  assign viol_o     = valid_i && (attr_i.nx || (wr_i && attr_i.wp));
  assign phys_o     = attr_i.host ? {xlat_i, addr_i[OFS_W-1:0]} : addr_i;
endmodule

// File: rtl/brk_latch.sv
module brk_latch #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              viol_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              clr_i,
  output logic              brk_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_o
);
  logic              brk_q, wr_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (viol_i && (!brk_q || clr_i)) begin
      brk_q  <= 1'b1;
      addr_q <= addr_i;
      wr_q   <= wr_i;
    end else if (clr_i) begin
      brk_q  <= 1'b0;
    end
  end

  assign brk_o  = brk_q;
  assign addr_o = addr_q;
  assign wr_o   = wr_q;

  assert_brk_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> brk_q);
  assert_brk_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_q && !clr_i) |=> (brk_q && $stable(addr_q) && $stable(wr_q)));
  assert_brk_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !viol_i) |=> !brk_q);
endmodule

// File: rtl/mem_mapper.sv
module mem_mapper import mapper_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 10,
  localparam int IDX_W = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              emu_run_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_host_i,
  input  logic              cfg_wp_i,
  input  logic              cfg_nx_i,
  input  logic [IDX_W-1:0]  cfg_xlat_i,
  input  logic              bus_valid_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              host_sel_o,
  output logic              tgt_sel_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] phys_addr_o,
  input  logic              brk_clr_i,
  output logic              brk_o,
  output logic [ADDR_W-1:0] brk_addr_o,
  output logic              brk_wr_o
);
  map_attr_t        cfg_attr, attr;
  logic [IDX_W-1:0] xlat;
  logic             viol;

  assign cfg_attr = '{host: cfg_host_i, wp: cfg_wp_i, nx: cfg_nx_i};

  map_table #(.IDX_W(IDX_W)) u_table (
    .clk_i, .rst_ni,
    .lock_i(emu_run_i), .we_i(cfg_we_i), .wr_idx_i(cfg_idx_i),
    .wr_attr_i(cfg_attr), .wr_xlat_i(cfg_xlat_i),
    .rd_idx_i(bus_addr_i[ADDR_W-1:OFS_W]), .attr_o(attr), .xlat_o(xlat)
  );

  map_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_dec (
    .valid_i(bus_valid_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .attr_i(attr), .xlat_i(xlat),
    .host_sel_o, .tgt_sel_o, .wr_en_o, .phys_o(phys_addr_o), .viol_o(viol)
  );

  brk_latch #(.ADDR_W(ADDR_W)) u_brk (
    .clk_i, .rst_ni, .viol_i(viol), .addr_i(bus_addr_i), .wr_i(bus_wr_i),
    .clr_i(brk_clr_i), .brk_o, .addr_o(brk_addr_o), .wr_o(brk_wr_o)
  );

  assert_ofs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[OFS_W-1:0] == bus_addr_i[OFS_W-1:0]);
  assert_wp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (bus_wr_i && (host_sel_o || tgt_sel_o) && !attr.wp));
  assert_nx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && attr.nx) |-> (!host_sel_o && !tgt_sel_o && !wr_en_o));
  assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({host_sel_o, tgt_sel_o}) <= 1);
endmodule

// File: tb/sim_mem_mapper.sv
module sim_mem_mapper;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic emu_run_i = 0, cfg_we_i = 0, cfg_host_i = 0, cfg_wp_i = 0, cfg_nx_i = 0;
  logic [5:0] cfg_idx_i = 0, cfg_xlat_i = 0;
  logic bus_valid_i = 0, bus_wr_i = 0, brk_clr_i = 0;
  logic [15:0] bus_addr_i = 0;
  logic host_sel_o, tgt_sel_o, wr_en_o, brk_o, brk_wr_o;
  logic [15:0] phys_addr_o, brk_addr_o;

  always #2.5 clk_i = ~clk_i;

  mem_mapper u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit m_host[64], m_wp[64], m_nx[64];
  int m_xl[64];
  bit m_brk, m_bwr;
  int m_baddr;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) begin
        m_host[i] = 0; m_wp[i] = 0; m_nx[i] = 0; m_xl[i] = i;
      end
      m_brk = 0; m_bwr = 0; m_baddr = 0;
    end else begin
      int ix;
      bit v;
      ix = int'(bus_addr_i[15:10]);
      v = bus_valid_i && (m_nx[ix] || (bus_wr_i && m_wp[ix]));
      if (v && (!m_brk || brk_clr_i)) begin
        m_brk = 1; m_baddr = int'(bus_addr_i); m_bwr = bus_wr_i;
      end else if (brk_clr_i) m_brk = 0;
      if (cfg_we_i && !emu_run_i) begin
        m_host[cfg_idx_i] = cfg_host_i; m_wp[cfg_idx_i] = cfg_wp_i;
        m_nx[cfg_idx_i] = cfg_nx_i; m_xl[cfg_idx_i] = int'(cfg_xlat_i);
      end
    end
  end

  task automatic cmp_all();
    int ix, ep;
    bit pres;
    ix = int'(bus_addr_i[15:10]);
    pres = bus_valid_i && !m_nx[ix];
    ep = m_host[ix] ? ((m_xl[ix] << 10) | int'(bus_addr_i[9:0])) : int'(bus_addr_i);
    chk("R2/R5 tgt_sel", tgt_sel_o, pres && !m_host[ix]);
    chk("R3/R5 host_sel", host_sel_o, pres && m_host[ix]);
    chk("R4 wr_en", wr_en_o, pres && bus_wr_i && !m_wp[ix]);
    if (bus_valid_i) chk("R1/R3 phys", phys_addr_o, ep);
    chk("R6 brk", brk_o, m_brk);
    if (m_brk) begin
      chk("R6 brk_addr", brk_addr_o, m_baddr);
      chk("R6 brk_wr", brk_wr_o, m_bwr);
    end
  endtask

  task automatic step();
    #1 cmp_all();
    @(negedge clk_i);
    cfg_we_i = 0; brk_clr_i = 0;
  endtask

  task automatic cfg(int ix, bit h, bit wp, bit nx, int xl);
    cfg_we_i = 1; cfg_idx_i = 6'(ix); cfg_host_i = h; cfg_wp_i = wp;
    cfg_nx_i = nx; cfg_xlat_i = 6'(xl);
    step();
  endtask

  task automatic acc(int a, bit wr);
    bus_valid_i = 1; bus_addr_i = 16'(a); bus_wr_i = wr;
    step();
    bus_valid_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R8: reset state
    bus_valid_i = 1; bus_addr_i = 16'hABCD; bus_wr_i = 1;
    #1;
    chk("R8 tgt after reset", tgt_sel_o, 1);
    chk("R8 wr_en after reset", wr_en_o, 1);
    chk("R8 identity phys", phys_addr_o, 16'hABCD);
    chk("R8 brk low", brk_o, 0);
    @(negedge clk_i);
    bus_valid_i = 0;
    // R9 / R3: host block with translation
    cfg(5, 1, 0, 0, 6'h2A);
    bus_valid_i = 1; bus_addr_i = 16'h1555; bus_wr_i = 0;
    #1;
    chk("R9 write visible", host_sel_o, 1);
    chk("R3 xlat", phys_addr_o, 16'hA955);
    @(negedge clk_i);
    bus_valid_i = 0;
    // R7: write ignored while running
    emu_run_i = 1;
    cfg(5, 0, 1, 1, 6'h01);
    emu_run_i = 0;
    bus_valid_i = 1; bus_addr_i = 16'h17FF; bus_wr_i = 1;
    #1;
    chk("R7 entry unchanged sel", host_sel_o, 1);
    chk("R7 entry unchanged phys", phys_addr_o, 16'hABFF);
    chk("R7 entry unchanged we", wr_en_o, 1);
    @(negedge clk_i);
    bus_valid_i = 0;
    step();
    chk("R7 no brk", brk_o, 0);
    // R4: write-protected target block
    cfg(2, 0, 1, 0, 2);
    acc(16'h0812, 0);
    chk("R4 read no brk", brk_o, 0);
    acc(16'h0813, 1);
    chk("R4 write brk", brk_o, 1);
    chk("R6 addr", brk_addr_o, 16'h0813);
    // R5: absent overrides other fields; R6 holds first record
    cfg(9, 1, 1, 1, 7);
    acc(16'h2400, 0);
    chk("R6 held", brk_addr_o, 16'h0813);
    brk_clr_i = 1; step();
    chk("R6 cleared", brk_o, 0);
    // R6: clear with a new violation captures the new one
    acc(16'h2401, 0);
    chk("R5 brk", brk_o, 1);
    brk_clr_i = 1; acc(16'h0900, 1);
    chk("R6 clr+viol addr", brk_addr_o, 16'h0900);
    chk("R6 clr+viol wr", brk_wr_o, 1);
    brk_clr_i = 1; step();
    // random phase
    for (int k = 0; k < 3000; k++) begin
      emu_run_i = $urandom_range(1, 0) == 1;
      cfg_we_i = $urandom_range(3, 0) == 0;
      cfg_idx_i = 6'($urandom); cfg_host_i = 1'($urandom);
      cfg_wp_i = $urandom_range(2, 0) == 0; cfg_nx_i = $urandom_range(5, 0) == 0;
      cfg_xlat_i = 6'($urandom);
      bus_valid_i = 1'($urandom); bus_wr_i = 1'($urandom);
      bus_addr_i = 16'($urandom);
      brk_clr_i = $urandom_range(7, 0) == 0;
      step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule